// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Alarm

This block keeps wall-clock time and date as packed BCD: second, minute, hour (24-hour form), day of month, month (01 to 12) and a two-digit year (00 to 99). A slow tick enable, nominally 32768 Hz, drives a prescaler. Once per second the prescaler completes and the calendar advances with full carry. The carry knows month lengths of 28, 29, 30 and 31 days, and it decides leap years by the year value modulo 4.

Software sets the time through a load strobe. The load takes effect on the next clock edge and restarts the one-second prescaler. A second strobe loads a six-field alarm. The alarm event pulses only when every field of the freshly advanced time equals the alarm, and it can never fire on more than one clock per second.

The block also produces one-clock event pulses when the second advances and when the minute, hour and day roll over. A busy output rises for the final tick period before each advance, so software knows when the fields are about to change. Counting happens only while the run input is high.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time reads 00:00:00 on day 01, month 01, year 00 (all packed BCD), busy is low and every event output is low.
- R2: While run is high the time advances by one second on every TICKS_PER_SEC-th clock that has tick high; clocks with tick low do not count.
- R3: Busy is high exactly while the prescaler holds its final count and run is high. The fields change on the tick that ends that period, so with tick high every clock, busy is high for the one clock just before the change.
- R4: Seconds and minutes count in BCD from 00 to 59 and wrap to 00. Hours count from 00 to 23 and wrap to 00, carrying into the next field.
- R5: The day wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the others, and 28 or 29 for month 02. The month wraps from 12 to 01, and the year wraps from 99 to 00.
- R6: A year counts as a leap year when its value is divisible by 4. Years 00, 12 and 24 are leap years; year 23 is not.
- R7: While run is low the fields hold, the prescaler holds, busy stays low and no event pulses.
- R8: The time load strobe writes all six fields on the next clock edge, even while counting, and restarts the prescaler at zero. The first advance then comes a full TICKS_PER_SEC ticks after the load.
- R9: The alarm event pulses for one clock, in the same cycle the advanced time appears, only when all six fields equal the stored alarm. There is no masking of fields. The alarm resets to all zeros, which never matches.
- R10: Event outputs pulse for one clock with each advance: ev_sec on every advance, ev_min when the seconds wrap, ev_hour when the minutes also wrap, and ev_day when the hours also wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slow timebase enable, one clock per timebase period |
| run | input | 1 | High to count, low to freeze |
| ld_time | input | 1 | Load strobe for the six time fields |
| ld_alarm | input | 1 | Load strobe for the six alarm fields |
| in_sec | input | 8 | BCD seconds to load |
| in_min | input | 8 | BCD minutes to load |
| in_hour | input | 8 | BCD hours to load |
| in_day | input | 8 | BCD day of month to load |
| in_mon | input | 8 | BCD month to load |
| in_year | input | 8 | BCD year to load |
| sec | output | 8 | Current BCD seconds |
| min | output | 8 | Current BCD minutes |
| hour | output | 8 | Current BCD hours |
| day | output | 8 | Current BCD day of month |
| mon | output | 8 | Current BCD month |
| year | output | 8 | Current BCD year |
| busy | output | 1 | High during the tick period before an advance |
| ev_sec | output | 1 | Pulse on each second advance |
| ev_min | output | 1 | Pulse on minute rollover |
| ev_hour | output | 1 | Pulse on hour rollover |
| ev_day | output | 1 | Pulse on day rollover |
| alarm_ev | output | 1 | Pulse when the advanced time equals the alarm |

## Verification
The bench aims at the calendar edges. It loads 23:59:59 on the last day of 31-day, 30-day and February months, including the leap years 00, 12 and 24, the common year 23, and the December 99 rollover. A wrong month-length table or a binary-style leap test would land on a wrong day, or on an invalid BCD value such as 0x1A. It also counts clocks from a mid-second load to the next advance, and checks that busy precedes the advance. A prescaler that is not restarted, or a busy flag that is off by one, would show up as a short first second or busy low before the change. Alarm tests put the matching second between two non-matching ones and try an alarm that differs only in the year. A design that matched on fewer fields, or compared the stale time, would pulse in the wrong cycle or fire when it should stay quiet.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  input  logic       ld_time,
  input  logic       ld_alarm,
  input  logic [7:0] in_sec,
  input  logic [7:0] in_min,
  input  logic [7:0] in_hour,
  input  logic [7:0] in_day,
  input  logic [7:0] in_mon,
  input  logic [7:0] in_year,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic [7:0] day,
  output logic [7:0] mon,
  output logic [7:0] year,
  output logic       busy,
  output logic       ev_sec,
  output logic       ev_min,
  output logic       ev_hour,
  output logic       ev_day,
  output logic       alarm_ev
);
  localparam int PW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic [PW-1:0] presc;
  logic [7:0] a_sec, a_min, a_hour, a_day, a_mon, a_year;
  logic [7:0] n_sec, n_min, n_hour, n_day, n_mon, n_year;
  logic [7:0] dim;
  logic       leap, sec_wr, min_wr, hr_wr, day_wr, mon_wr, match;
  logic [47:0] cur_t, alm_t;

  assign busy = run && (presc == LAST);

  assign leap = year[4] ? (year[3:0] == 4'd2 || year[3:0] == 4'd6)
                        : (year[3:0] == 4'd0 || year[3:0] == 4'd4 || year[3:0] == 4'd8);

  always_comb begin
    case (mon)
      8'h02:                      dim = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: dim = 8'h30;
      default:                    dim = 8'h31;
    endcase
  end

  assign sec_wr = sec >= 8'h59;
  assign min_wr = sec_wr && (min >= 8'h59);
  assign hr_wr  = min_wr && (hour >= 8'h23);
  assign day_wr = hr_wr && (day >= dim);
  assign mon_wr = day_wr && (mon >= 8'h12);

  assign n_sec  = sec_wr ? 8'h00 : bcd_inc(sec);
  assign n_min  = sec_wr ? (min_wr ? 8'h00 : bcd_inc(min)) : min;
  assign n_hour = min_wr ? (hr_wr ? 8'h00 : bcd_inc(hour)) : hour;
  assign n_day  = hr_wr ? (day_wr ? 8'h01 : bcd_inc(day)) : day;
  assign n_mon  = day_wr ? (mon_wr ? 8'h01 : bcd_inc(mon)) : mon;
  assign n_year = mon_wr ? ((year >= 8'h99) ? 8'h00 : bcd_inc(year)) : year;

  assign cur_t = {year, mon, day, hour, min, sec};
  assign alm_t = {a_year, a_mon, a_day, a_hour, a_min, a_sec};
  assign match = {n_year, n_mon, n_day, n_hour, n_min, n_sec} == alm_t;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc <= '0;
      {year, mon, day, hour, min, sec} <= {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
      {a_year, a_mon, a_day, a_hour, a_min, a_sec} <= '0;
      {ev_sec, ev_min, ev_hour, ev_day, alarm_ev} <= '0;
    end else begin
      {ev_sec, ev_min, ev_hour, ev_day, alarm_ev} <= '0;
      if (ld_alarm)
        {a_year, a_mon, a_day, a_hour, a_min, a_sec} <= {in_year, in_mon, in_day, in_hour, in_min, in_sec};
      if (ld_time) begin
        presc <= '0;
        {year, mon, day, hour, min, sec} <= {in_year, in_mon, in_day, in_hour, in_min, in_sec};
      end else if (run && tick) begin
        if (presc == LAST) begin
          presc    <= '0;
          {year, mon, day, hour, min, sec} <= {n_year, n_mon, n_day, n_hour, n_min, n_sec};
          ev_sec   <= 1'b1;
          ev_min   <= sec_wr;
          ev_hour  <= min_wr;
          ev_day   <= hr_wr;
          alarm_ev <= match;
        end else begin
          presc <= presc + 1'b1;
        end
      end
    end
  end

  AST_BUSY_BEFORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sec |-> $past(busy));  // R3
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_time) |=> $stable(cur_t));  // R7
  AST_IDLE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !busy);  // R7
  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ld_time |=> (cur_t == $past({in_year, in_mon, in_day, in_hour, in_min, in_sec})) && !ev_sec);  // R8
  AST_ALARM_ALL_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_ev |-> (ev_sec && cur_t == $past(alm_t)));  // R9
  AST_MIN_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_min |-> (ev_sec && sec == 8'h00));  // R10
  AST_DAY_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_day |-> (ev_hour && ev_min && hour == 8'h00 && min == 8'h00));  // R10
endmodule

// File: tb/tb_bcd_rtc.sv
module tb_bcd_rtc;
  localparam int N = 4;
  logic clk = 0, rst_n = 0, tick = 1, run = 1, ld_time = 0, ld_alarm = 0;
  logic [7:0] in_sec = 0, in_min = 0, in_hour = 0, in_day = 0, in_mon = 0, in_year = 0;
  logic [7:0] sec, min, hour, day, mon, year;
  logic busy, ev_sec, ev_min, ev_hour, ev_day, alarm_ev;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bcd_rtc #(.TICKS_PER_SEC(N)) dut (.*);

  function automatic logic [47:0] pk(input logic [7:0] y, mo, d, h, mi, s);
    return {y, mo, d, h, mi, s};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_t(input logic [47:0] t);
    @(negedge clk);
    {in_year, in_mon, in_day, in_hour, in_min, in_sec} = t;
    ld_time = 1;
    @(negedge clk);
    ld_time = 0;
  endtask

  task automatic load_a(input logic [47:0] t);
    @(negedge clk);
    {in_year, in_mon, in_day, in_hour, in_min, in_sec} = t;
    ld_alarm = 1;
    @(negedge clk);
    ld_alarm = 0;
  endtask

  task automatic wait_sec(output int cyc, output bit pb);
    cyc = 0;
    do begin
      pb = busy;
      @(negedge clk);
      cyc++;
    end while (!ev_sec && cyc < 200);
  endtask

  task automatic step_chk(input logic [47:0] t, input logic [47:0] exp, input logic [3:0] evs, input string req);
    int cyc; bit pb;
    load_t(t);
    wait_sec(cyc, pb);
    chk({year, mon, day, hour, min, sec} == exp, req, {year, mon, day, hour, min, sec}, exp);
    chk({ev_sec, ev_min, ev_hour, ev_day} == evs, "R10 events", 48'({ev_sec, ev_min, ev_hour, ev_day}), 48'(evs));
    chk(cyc == N && pb, "R3 busy/period", 48'(cyc), 48'(N));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk({year, mon, day, hour, min, sec} == pk(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00), "R1 reset time",
        {year, mon, day, hour, min, sec}, pk(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));
    chk({busy, ev_sec, ev_min, ev_hour, ev_day, alarm_ev} == 0, "R1 reset flags",
        48'({busy, ev_sec, ev_min, ev_hour, ev_day, alarm_ev}), 48'h0);
  endtask

  task automatic t_carry;
    step_chk(pk(8'h25, 8'h06, 8'h15, 8'h10, 8'h20, 8'h09), pk(8'h25, 8'h06, 8'h15, 8'h10, 8'h20, 8'h10), 4'b1000, "R4 units digit");
    step_chk(pk(8'h25, 8'h06, 8'h15, 8'h10, 8'h20, 8'h59), pk(8'h25, 8'h06, 8'h15, 8'h10, 8'h21, 8'h00), 4'b1100, "R4 second wrap");
    step_chk(pk(8'h25, 8'h06, 8'h15, 8'h19, 8'h59, 8'h59), pk(8'h25, 8'h06, 8'h15, 8'h20, 8'h00, 8'h00), 4'b1110, "R4 hour carry");
    step_chk(pk(8'h25, 8'h06, 8'h15, 8'h23, 8'h59, 8'h59), pk(8'h25, 8'h06, 8'h16, 8'h00, 8'h00, 8'h00), 4'b1111, "R4 hour wrap");
  endtask

  task automatic t_months;
    step_chk(pk(8'h25, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59), pk(8'h25, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00), 4'b1111, "R5 30-day month");
    step_chk(pk(8'h25, 8'h11, 8'h30, 8'h23, 8'h59, 8'h59), pk(8'h25, 8'h12, 8'h01, 8'h00, 8'h00, 8'h00), 4'b1111, "R5 month 11");
    step_chk(pk(8'h25, 8'h01, 8'h30, 8'h23, 8'h59, 8'h59), pk(8'h25, 8'h01, 8'h31, 8'h00, 8'h00, 8'h00), 4'b1111, "R5 31-day month");
    step_chk(pk(8'h25, 8'h09, 8'h19, 8'h23, 8'h59, 8'h59), pk(8'h25, 8'h09, 8'h20, 8'h00, 8'h00, 8'h00), 4'b1111, "R5 day digit");
    step_chk(pk(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59), pk(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00), 4'b1111, "R5 year wrap");
    step_chk(pk(8'h09, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59), pk(8'h10, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00), 4'b1111, "R5 year digit");
  endtask

  task automatic t_leap;
    step_chk(pk(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59), pk(8'h23, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00), 4'b1111, "R6 common year");
    step_chk(pk(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59), pk(8'h24, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00), 4'b1111, "R6 leap 24");
    step_chk(pk(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59), pk(8'h24, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00), 4'b1111, "R6 leap end");
    step_chk(pk(8'h12, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59), pk(8'h12, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00), 4'b1111, "R6 leap 12");
    step_chk(pk(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59), pk(8'h00, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00), 4'b1111, "R6 leap 00");
  endtask

  task automatic t_tick_gate;
    logic [47:0] t0;
    int evs = 0;
    @(negedge clk);
    tick = 0;
    t0 = {year, mon, day, hour, min, sec};
    for (int i = 0; i < 3 * N; i++) begin
      @(negedge clk);
      if (ev_sec) evs++;
    end
    chk({year, mon, day, hour, min, sec} == t0 && evs == 0, "R2 tick low holds", {year, mon, day, hour, min, sec}, t0);
    tick = 1;
  endtask

  task automatic t_freeze;
    logic [47:0] t0;
    int evs = 0, bz = 0;
    load_t(pk(8'h25, 8'h03, 8'h10, 8'h08, 8'h30, 8'h59));
    @(negedge clk);
    run = 0;
    t0 = {year, mon, day, hour, min, sec};
    for (int i = 0; i < 5 * N; i++) begin
      @(negedge clk);
      if (ev_sec) evs++;
      if (busy) bz++;
    end
    chk({year, mon, day, hour, min, sec} == t0, "R7 frozen fields", {year, mon, day, hour, min, sec}, t0);
    chk(evs == 0 && bz == 0, "R7 no busy/events", 48'(evs + bz), 48'h0);
    run = 1;
    begin
      int cyc; bit pb;
      wait_sec(cyc, pb);
      chk(cyc == N - 1 && min == 8'h31, "R7 resumes where held", 48'(cyc), 48'(N - 1));
    end
  endtask

  task automatic t_restart;
    int cyc; bit pb;
    @(negedge clk); @(negedge clk);
    load_t(pk(8'h25, 8'h07, 8'h04, 8'h01, 8'h02, 8'h03));
    chk({year, mon, day, hour, min, sec} == pk(8'h25, 8'h07, 8'h04, 8'h01, 8'h02, 8'h03), "R8 load next edge",
        {year, mon, day, hour, min, sec}, pk(8'h25, 8'h07, 8'h04, 8'h01, 8'h02, 8'h03));
    wait_sec(cyc, pb);
    chk(cyc == N, "R8 prescaler restart", 48'(cyc), 48'(N));
    chk(sec == 8'h04, "R2 one second per period", 48'(sec), 48'h04);
  endtask

  task automatic t_alarm;
    int cyc; bit pb;
    load_a(pk(8'h25, 8'h06, 8'h15, 8'h12, 8'h00, 8'h02));
    load_t(pk(8'h25, 8'h06, 8'h15, 8'h12, 8'h00, 8'h00));
    wait_sec(cyc, pb);
    chk(!alarm_ev, "R9 no early alarm", 48'(alarm_ev), 48'h0);
    wait_sec(cyc, pb);
    chk(alarm_ev && sec == 8'h02, "R9 alarm on match", 48'({alarm_ev, sec}), 48'h102);
    @(negedge clk);
    chk(!alarm_ev, "R9 single pulse", 48'(alarm_ev), 48'h0);
    wait_sec(cyc, pb);
    chk(!alarm_ev, "R9 no alarm after", 48'(alarm_ev), 48'h0);
    load_a(pk(8'h26, 8'h06, 8'h15, 8'h12, 8'h00, 8'h05));
    load_t(pk(8'h25, 8'h06, 8'h15, 8'h12, 8'h00, 8'h04));
    wait_sec(cyc, pb);
    chk(!alarm_ev && sec == 8'h05, "R9 year mismatch quiet", 48'({alarm_ev, sec}), 48'h005);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_restart();
    t_carry();
    t_months();
    t_leap();
    t_tick_gate();
    t_freeze();
    t_alarm();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule